// File: doc/BRIEF.md
# Multi-Width Aliased Register File

This block holds eight 32-bit general registers and lets each one be reached through five overlapping views: the whole 32-bit longword, its upper 16-bit half, its lower 16-bit half, or either byte of the lower half. Two combinational read ports and one clocked write port each take a register index and a view code. A narrow write replaces only the bits its view covers. Read data is right-aligned and zero-extended to 32 bits.

The highest-numbered register also acts as the stack pointer, and its clipped address is always on a dedicated output. A pointer adjust port steps any register by 1, 2 or 4, upward or downward, across all 32 bits in one cycle. That lets a 16-bit address step carry into or borrow from the upper half. The same port drives the address of the access: the old value for a post-increment and the new value for a pre-decrement. That address is clipped to 16 or 24 bits according to the address-width select. Registers have no reset value. While reset is held, all updates are blocked.

Top module: `alias_regfile`

## Requirements
- R1: View code 0 (long) writes all 32 bits and reads back the full word. Codes 5 to 7 act exactly like code 0.
- R2: View code 1 (upper) writes `wr_data[15:0]` into bits 31:16 and leaves bits 15:0 unchanged. A read with code 1 returns bits 31:16 zero-extended.
- R3: View code 2 (lower) writes `wr_data[15:0]` into bits 15:0 and leaves bits 31:16 unchanged. A read with code 2 returns bits 15:0 zero-extended.
- R4: View code 3 (high byte) writes `wr_data[7:0]` into bits 15:8 and leaves all other bits unchanged. A read with code 3 returns bits 15:8 zero-extended.
- R5: View code 4 (low byte) writes `wr_data[7:0]` into bits 7:0 and leaves all other bits unchanged. A read with code 4 returns bits 7:0 zero-extended.
- R6: Both read ports are combinational and independent. A write clocked in at one edge is visible on the read ports from that edge onward.
- R7: An adjust with step code 00, 01 or 1x changes the selected register by 1, 2 or 4 respectively, subtracting when `adj_down` is 1. The step applies to all 32 bits, so a carry or borrow crosses from bit 15 into bit 16.
- R8: `ptr_addr` shows the old register value on an increment and the decremented value on a decrement. It is clipped to bits 15:0 when `addr_wide` is 0 and to bits 23:0 when `addr_wide` is 1, with zeros above.
- R9: `sp_addr` is register 7, clipped the same way as in R8. Register 7 otherwise behaves as an ordinary register.
- R10: When a write and an adjust target the same register in one cycle, the write view is merged over the adjusted value.
- R11: While `rst_n` is 0, writes and adjusts have no effect, and register contents are not cleared.
- R12: A register that is neither written nor adjusted keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; blocks updates |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 3 | Read port 0 view code |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 3 | Read port 1 view code |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 3 | Write view code |
| wr_data | input | 32 | Write data, right-aligned |
| adj_en | input | 1 | Pointer adjust enable |
| adj_idx | input | 3 | Register to adjust |
| adj_step | input | 2 | Step code: 00=1, 01=2, 1x=4 |
| adj_down | input | 1 | 1 = pre-decrement, 0 = post-increment |
| addr_wide | input | 1 | 1 = 24-bit addresses, 0 = 16-bit |
| ptr_addr | output | 32 | Clipped access address from the adjust port |
| sp_addr | output | 32 | Clipped stack pointer (register 7) |

## Verification
The bench goes after the carry from 0x0000FFFF and the borrow from 0x00010000. A design that stepped only the lower half would leave the upper half untouched and read back 0x00000000 or 0x0001FFFF. It drives a byte write and an adjust to the same register in one cycle. A design that let either one win outright would lose the adjust or the byte. It checks the pre-decrement address against the post-increment address under both clip widths, so a swapped choice or a wrong mask shows up in `ptr_addr`. It also pulses reset while a write is pending, which exposes a design that clears or updates its registers during reset.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;

    localparam int unsigned RF_WORD_W = 32;

    typedef enum logic [2:0] {
        VIEW_LONG  = 3'd0,
        VIEW_UPPER = 3'd1,
        VIEW_LOWER = 3'd2,
        VIEW_HBYTE = 3'd3,
        VIEW_LBYTE = 3'd4
    } view_e;

endpackage

// File: rtl/rf_view_read.sv
module rf_view_read
    import alias_rf_pkg::*;
#(
    parameter int unsigned DW = RF_WORD_W
) (
    input  logic [DW-1:0] word_i,
    input  logic [2:0]    view_i,
    output logic [DW-1:0] data_o
);
    localparam int unsigned HW = DW / 2;
    localparam int unsigned BW = DW / 4;

    always_comb begin
        data_o = '0;
        case (view_e'(view_i))
            VIEW_UPPER: data_o[HW-1:0] = word_i[DW-1:HW];
            VIEW_LOWER: data_o[HW-1:0] = word_i[HW-1:0];
            VIEW_HBYTE: data_o[BW-1:0] = word_i[HW-1:HW-BW];
            VIEW_LBYTE: data_o[BW-1:0] = word_i[BW-1:0];
            default:    data_o         = word_i;
        endcase
    end
endmodule

// File: rtl/rf_view_merge.sv
module rf_view_merge
    import alias_rf_pkg::*;
#(
    parameter int unsigned DW = RF_WORD_W
) (
    input  logic [DW-1:0] base_i,
    input  logic [DW-1:0] data_i,
    input  logic [2:0]    view_i,
    output logic [DW-1:0] word_o
);
    localparam int unsigned HW = DW / 2;
    localparam int unsigned BW = DW / 4;

    always_comb begin
        word_o = base_i;
        case (view_e'(view_i))
            VIEW_UPPER: word_o[DW-1:HW]    = data_i[HW-1:0];
            VIEW_LOWER: word_o[HW-1:0]     = data_i[HW-1:0];
            VIEW_HBYTE: word_o[HW-1:HW-BW] = data_i[BW-1:0];
            VIEW_LBYTE: word_o[BW-1:0]     = data_i[BW-1:0];
            default:    word_o             = data_i;
        endcase
    end
endmodule

// File: rtl/rf_addr_clip.sv
module rf_addr_clip #(
    parameter int unsigned DW        = 32,
    parameter int unsigned WIDE_AW   = 24,
    parameter int unsigned NARROW_AW = 16
) (
    input  logic [DW-1:0] word_i,
    input  logic          wide_i,
    output logic [DW-1:0] addr_o
);
    localparam logic [DW-1:0] ONE         = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] WIDE_MASK   = (ONE << WIDE_AW) - ONE;
    localparam logic [DW-1:0] NARROW_MASK = (ONE << NARROW_AW) - ONE;

    assign addr_o = word_i & (wide_i ? WIDE_MASK : NARROW_MASK);
endmodule

// File: rtl/rf_ptr_step.sv
module rf_ptr_step #(
    parameter int unsigned DW        = 32,
    parameter int unsigned WIDE_AW   = 24,
    parameter int unsigned NARROW_AW = 16
) (
    input  logic [DW-1:0] word_i,
    input  logic [1:0]    step_i,
    input  logic          down_i,
    input  logic          wide_i,
    output logic [DW-1:0] word_o,
    output logic [DW-1:0] addr_o
);
    logic [DW-1:0] amount;
    logic [DW-1:0] access_word;

    always_comb begin
        amount = '0;
        unique case (step_i)
            2'b00:   amount[0] = 1'b1;
            2'b01:   amount[1] = 1'b1;
            default: amount[2] = 1'b1;
        endcase
    end

    assign word_o      = down_i ? (word_i - amount) : (word_i + amount);
    assign access_word = down_i ? word_o : word_i;

    rf_addr_clip #(
        .DW(DW), .WIDE_AW(WIDE_AW), .NARROW_AW(NARROW_AW)
    ) i_clip (
        .word_i (access_word),
        .wide_i (wide_i),
        .addr_o (addr_o)
    );
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
    import alias_rf_pkg::*;
#(
    parameter int unsigned NREG      = 8,
    parameter int unsigned DW        = RF_WORD_W,
    parameter int unsigned WIDE_AW   = 24,
    parameter int unsigned NARROW_AW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd0_idx,
    input  logic [2:0]              rd0_size,
    output logic [DW-1:0]           rd0_data,
    input  logic [$clog2(NREG)-1:0] rd1_idx,
    input  logic [2:0]              rd1_size,
    output logic [DW-1:0]           rd1_data,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [2:0]              wr_size,
    input  logic [DW-1:0]           wr_data,
    input  logic                    adj_en,
    input  logic [$clog2(NREG)-1:0] adj_idx,
    input  logic [1:0]              adj_step,
    input  logic                    adj_down,
    input  logic                    addr_wide,
    output logic [DW-1:0]           ptr_addr,
    output logic [DW-1:0]           sp_addr
);
    localparam int unsigned IW     = $clog2(NREG);
    localparam int unsigned SP_IDX = NREG - 1;
    localparam int unsigned BW     = DW / 4;

    logic [DW-1:0]   rf_q [NREG];
    logic [DW-1:0]   adj_next;
    logic [DW-1:0]   wr_base;
    logic [DW-1:0]   wr_next;
    logic [NREG-1:0] wr_hit;
    logic [NREG-1:0] adj_hit;
    logic            same_target;

    // read views
    rf_view_read #(.DW(DW)) i_read0 (
        .word_i (rf_q[rd0_idx]), .view_i (rd0_size), .data_o (rd0_data)
    );
    rf_view_read #(.DW(DW)) i_read1 (
        .word_i (rf_q[rd1_idx]), .view_i (rd1_size), .data_o (rd1_data)
    );

    // pointer step and access address
    rf_ptr_step #(
        .DW(DW), .WIDE_AW(WIDE_AW), .NARROW_AW(NARROW_AW)
    ) i_step (
        .word_i (rf_q[adj_idx]),
        .step_i (adj_step),
        .down_i (adj_down),
        .wide_i (addr_wide),
        .word_o (adj_next),
        .addr_o (ptr_addr)
    );

    // stack pointer address
    rf_addr_clip #(
        .DW(DW), .WIDE_AW(WIDE_AW), .NARROW_AW(NARROW_AW)
    ) i_sp_clip (
        .word_i (rf_q[SP_IDX]),
        .wide_i (addr_wide),
        .addr_o (sp_addr)
    );

    // write merge, layered over a same-cycle adjust
    assign same_target = adj_en && (adj_idx == wr_idx);
    assign wr_base     = same_target ? adj_next : rf_q[wr_idx];

    rf_view_merge #(.DW(DW)) i_merge (
        .base_i (wr_base),
        .data_i (wr_data),
        .view_i (wr_size),
        .word_o (wr_next)
    );

    // per-register target decode
    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign wr_hit[g]  = wr_en  && (wr_idx  == IW'(g));
        assign adj_hit[g] = adj_en && (adj_idx == IW'(g));
    end

    // storage: no reset value, updates blocked while in reset
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_hit[i]) begin
                    rf_q[i] <= wr_next;
                end else if (adj_hit[i]) begin
                    rf_q[i] <= adj_next;
                end
            end
        end
    end

    // checker state: expected step magnitude of the last request
    logic [DW-1:0] chk_step_q;
    always_ff @(posedge clk) begin
        chk_step_q <= {{(DW-3){1'b0}}, adj_step[1], (adj_step == 2'b01), (adj_step == 2'b00)};
    end

    AST_LONG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == VIEW_LONG) |=> rf_q[$past(wr_idx)] == $past(wr_data)); // R1

    AST_LBYTE_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == VIEW_LBYTE && !same_target)
        |=> rf_q[$past(wr_idx)][DW-1:BW] == $past(rf_q[wr_idx][DW-1:BW])); // R5

    AST_STEP_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_en && !(wr_en && wr_idx == adj_idx))
        |=> ($past(adj_down) ? ($past(rf_q[adj_idx]) - rf_q[$past(adj_idx)])
                             : (rf_q[$past(adj_idx)] - $past(rf_q[adj_idx]))) == chk_step_q); // R7

    for (genvar h = 0; h < NREG; h++) begin : g_hold_chk
        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_hit[h] && !adj_hit[h]) |=> $stable(rf_q[h])); // R12
    end
endmodule

// File: tb/test_alias_regfile.sv
`timescale 1ns/1ps
module test_alias_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd0_idx = '0, rd0_size = '0, rd1_idx = '0, rd1_size = '0;
    logic [31:0] rd0_data, rd1_data;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0, wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        adj_en = 1'b0;
    logic [2:0]  adj_idx = '0;
    logic [1:0]  adj_step = '0;
    logic        adj_down = 1'b0, addr_wide = 1'b0;
    logic [31:0] ptr_addr, sp_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit chk_on = 1'b0;
    logic [31:0] model [8];

    always #4 clk = ~clk;

    alias_regfile i_alias_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
        .adj_en(adj_en), .adj_idx(adj_idx), .adj_step(adj_step), .adj_down(adj_down),
        .addr_wide(addr_wide), .ptr_addr(ptr_addr), .sp_addr(sp_addr)
    );

    function automatic logic [31:0] f_view(logic [31:0] w, logic [2:0] v);
        case (v)
            3'd1:    return {16'h0, w[31:16]};
            3'd2:    return {16'h0, w[15:0]};
            3'd3:    return {24'h0, w[15:8]};
            3'd4:    return {24'h0, w[7:0]};
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] f_merge(logic [31:0] b, logic [31:0] d, logic [2:0] v);
        logic [31:0] r;
        r = b;
        case (v)
            3'd1:    r[31:16] = d[15:0];
            3'd2:    r[15:0]  = d[15:0];
            3'd3:    r[15:8]  = d[7:0];
            3'd4:    r[7:0]   = d[7:0];
            default: r        = d;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] f_amount(logic [1:0] c);
        if (c[1]) return 32'd4;
        return c[0] ? 32'd2 : 32'd1;
    endfunction

    function automatic logic [31:0] f_clip(logic [31:0] a, logic wide);
        return wide ? (a & 32'h00FF_FFFF) : (a & 32'h0000_FFFF);
    endfunction

    function automatic string f_tag(logic [2:0] v);
        case (v)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, check combinational outputs, update model
    task automatic do_op(input bit we, input logic [2:0] wi, input logic [2:0] ws,
                         input logic [31:0] wd, input bit ae, input logic [2:0] ai,
                         input logic [1:0] as, input bit ad, input bit wide,
                         input logic [2:0] r0i, input logic [2:0] r0s,
                         input logic [2:0] r1i, input logic [2:0] r1s);
        logic [31:0] adjusted;
        logic [31:0] base;
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
        adj_en = ae; adj_idx = ai; adj_step = as; adj_down = ad; addr_wide = wide;
        rd0_idx = r0i; rd0_size = r0s; rd1_idx = r1i; rd1_size = r1s;
        #1;
        adjusted = ad ? (model[ai] - f_amount(as)) : (model[ai] + f_amount(as));
        if (chk_on) begin
            check({"R6 port0 ", f_tag(r0s)}, rd0_data, f_view(model[r0i], r0s));
            check({"R6 port1 ", f_tag(r1s)}, rd1_data, f_view(model[r1i], r1s));
            check("R9 sp_addr", sp_addr, f_clip(model[7], wide));
            if (ae) check("R8 ptr_addr", ptr_addr, f_clip(ad ? adjusted : model[ai], wide));
        end
        if (rst_n) begin
            base = (ae && ai == wi) ? adjusted : model[wi];
            if (ae) model[ai] = adjusted;
            if (we) model[wi] = f_merge(base, wd, ws);
        end
    endtask

    task automatic idle();
        do_op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic peek(input logic [2:0] idx, input logic [2:0] v,
                        input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 0; adj_en = 0; rd0_idx = idx; rd0_size = v;
        #1;
        check(tag, rd0_data, exp);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        void'($urandom(32'd9137));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 8; i++) do_op(1, 3'(i), 0, 32'h1111_1111 * i, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle();
        chk_on = 1'b1;

        // R1 R2 R3 R4 R5 directed view writes
        do_op(1, 3'd5, 3'd0, 32'hCAFE_BABE, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        peek(3'd5, 3'd0, 32'hCAFE_BABE, "R1 long");
        do_op(1, 3'd5, 3'd1, 32'h0000_1234, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        peek(3'd5, 3'd0, 32'h1234_BABE, "R2 upper keeps lower");
        do_op(1, 3'd5, 3'd2, 32'hFFFF_5678, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        peek(3'd5, 3'd0, 32'h1234_5678, "R3 lower keeps upper");
        do_op(1, 3'd5, 3'd3, 32'h0000_00AA, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        peek(3'd5, 3'd0, 32'h1234_AA78, "R4 high byte");
        peek(3'd5, 3'd3, 32'h0000_00AA, "R4 high byte read");
        do_op(1, 3'd5, 3'd4, 32'hFFFF_FF33, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        peek(3'd5, 3'd0, 32'h1234_AA33, "R5 low byte");
        do_op(1, 3'd5, 3'd6, 32'h0BAD_F00D, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        peek(3'd5, 3'd0, 32'h0BAD_F00D, "R1 code 6 as long");

        // R7 R8 carry and borrow across halves in 16-bit mode
        do_op(1, 3'd2, 3'd0, 32'h0000_FFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op(0, 0, 0, 0, 1, 3'd2, 2'b00, 0, 0, 0, 0, 0, 0);
        peek(3'd2, 3'd0, 32'h0001_0000, "R7 carry into upper");
        do_op(0, 0, 0, 0, 1, 3'd2, 2'b00, 1, 0, 0, 0, 0, 0);
        peek(3'd2, 3'd0, 32'h0000_FFFF, "R7 borrow from upper");

        // R8 24-bit clip with step 4 and 2
        do_op(1, 3'd4, 3'd0, 32'hAB12_3456, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        do_op(0, 0, 0, 0, 1, 3'd4, 2'b10, 0, 1, 0, 0, 0, 0);
        peek(3'd4, 3'd0, 32'hAB12_345A, "R7 step four");
        do_op(0, 0, 0, 0, 1, 3'd4, 2'b01, 1, 1, 0, 0, 0, 0);
        peek(3'd4, 3'd0, 32'hAB12_3458, "R7 step two down");

        // R10 write merged over a same-cycle adjust
        do_op(1, 3'd3, 3'd0, 32'h0000_00FF, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op(1, 3'd3, 3'd4, 32'h0000_0055, 1, 3'd3, 2'b00, 0, 0, 0, 0, 0, 0);
        peek(3'd3, 3'd0, 32'h0000_0155, "R10 byte over adjust");

        // R9 stack pointer output
        do_op(1, 3'd7, 3'd0, 32'h1234_5678, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); wr_en = 0; adj_en = 0; addr_wide = 1; #1;
        check("R9 sp wide", sp_addr, 32'h0034_5678);
        addr_wide = 0; #1;
        check("R9 sp narrow", sp_addr, 32'h0000_5678);

        // R11 reset blocks updates and does not clear
        do_op(1, 3'd1, 3'd0, 32'h5EED_0001, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk) rst_n = 1'b0;
        do_op(1, 3'd1, 3'd0, 32'hDEAD_DEAD, 1, 3'd1, 2'b10, 0, 0, 0, 0, 0, 0);
        idle();
        @(negedge clk) rst_n = 1'b1;
        peek(3'd1, 3'd0, 32'h5EED_0001, "R11 held through reset");
        peek(3'd5, 3'd0, 32'h0BAD_F00D, "R12 untouched register");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            do_op(($urandom % 2) == 0, 3'($urandom), 3'($urandom % 8), $urandom,
                  ($urandom % 3) == 0, 3'($urandom), 2'($urandom), 1'($urandom),
                  1'($urandom), 3'($urandom), 3'($urandom % 5),
                  3'($urandom), 3'($urandom % 5));
        end
        idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule